// File: doc/BRIEF.md
# Rights Register Save/Restore Unit

This unit holds a 32-bit per-thread access-rights register together with a one-bit "in use" flag for that register, and moves the register to and from an extended-state memory image in the standard (non-compacted) layout. Software writes the register through a simple write port. A save command stores the value and then a header bitmap word. A restore command reads the bitmap word first and either loads the stored value or puts the register back into its initial configuration, which is all-zero.

The key hazard it models is that writing zero may silently clear the in-use flag. When that happens, a later save records bit 9 of the bitmap as 0, and a restore then ignores the stored value. A mode input picks between the two permitted behaviours for a zero write. A force input lets the saving side set bit 9 anyway, so that the stored value is always reloaded. A feature-enable input gates all memory traffic.

Top module: `rights_xstate_unit`

## Requirements
- R1: After reset the rights register is 0, the in-use flag is 0, `mem_valid` is 0 and `done` is 0.
- R2: While idle, writing a nonzero value loads it into the register and sets the in-use flag to 1.
- R3: While idle with `zero_clears_inuse`=0, writing 0 makes the register 0 and leaves the in-use flag unchanged.
- R4: While idle with `zero_clears_inuse`=1, writing 0 makes the register 0 and clears the in-use flag.
- R5: A save with `feat_en`=1 makes exactly two memory writes in this order: the register value to byte address BASE+2688, then the bitmap word to BASE+512. In the bitmap word, bit 9 equals (in-use OR `force_inuse` sampled with the command) and all other bits are 0. `done` pulses for one cycle, starting the cycle after the last accepted beat.
- R6: A restore with `feat_en`=1 first reads the bitmap word at BASE+512. If bit 9 is 0, it makes no further access, sets the register and the in-use flag to 0, and pulses `done`.
- R7: If the bitmap bit 9 read by a restore is 1, the unit reads BASE+2688 and loads that value. The in-use flag becomes 1 unless the loaded value is 0 and `zero_clears_inuse`=1.
- R8: With `feat_en`=0, a save or restore makes no memory access, leaves the register and the flag unchanged, and pulses `done` in the next cycle.
- R9: A memory request keeps `mem_valid`, `mem_we`, `mem_addr` and `mem_wdata` stable until `mem_ready` is seen high.
- R10: While `busy`=1, `wr_en`, `save_req` and `restore_req` are ignored.
- R11: If `save_req` and `restore_req` are both high in the same idle cycle, the save is performed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| feat_en | input | 1 | Component managed by save/restore when 1 |
| zero_clears_inuse | input | 1 | Writing zero clears the in-use flag when 1 |
| wr_en | input | 1 | Register write strobe |
| wr_data | input | 32 | Register write value |
| save_req | input | 1 | Start a save |
| restore_req | input | 1 | Start a restore |
| force_inuse | input | 1 | Force bitmap bit 9 to 1 on this save |
| rights | output | 32 | Current rights register value |
| inuse | output | 1 | In-use flag of the component |
| busy | output | 1 | Save or restore in progress |
| done | output | 1 | One-cycle completion pulse |
| mem_valid | output | 1 | Memory request valid |
| mem_ready | input | 1 | Memory request accepted |
| mem_we | output | 1 | 1 = write, 0 = read |
| mem_addr | output | AW | Byte address |
| mem_wdata | output | 32 | Write data |
| mem_rdata | input | 32 | Read data, valid with `mem_ready` on a read |

## Verification
On every cycle, the assertions check the following: how register writes affect the in-use flag in both modes, that requests stay stable under back-pressure, that the bitmap word carries bit 9 whenever the flag is set, that a cleared bitmap bit resets the register, that a read of the value location loads it, and that a disabled command completes without traffic. Some properties only the directed scenarios can show. These are the exact beat order and addresses, the full round trip in which a zero write in clearing mode causes a nonzero stored value to be discarded, the effect of the force input on that round trip, command priority, and that writes during a stalled save are ignored.

// File: rtl/rights_xstate_unit.sv
module rights_xstate_unit #(
  parameter int              AW   = 16,
  parameter logic [AW-1:0]   BASE = '0
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          feat_en,
  input  logic          zero_clears_inuse,
  input  logic          wr_en,
  input  logic [31:0]   wr_data,
  input  logic          save_req,
  input  logic          restore_req,
  input  logic          force_inuse,
  output logic [31:0]   rights,
  output logic          inuse,
  output logic          busy,
  output logic          done,
  output logic          mem_valid,
  input  logic          mem_ready,
  output logic          mem_we,
  output logic [AW-1:0] mem_addr,
  output logic [31:0]   mem_wdata,
  input  logic [31:0]   mem_rdata
);
  localparam int          COMP_BIT = 9;
  localparam logic [AW-1:0] HDR_ADDR = BASE + AW'(512);
  localparam logic [AW-1:0] VAL_ADDR = BASE + AW'(2688);

  typedef enum logic [2:0] {IDLE, SV_VAL, SV_HDR, RS_HDR, RS_VAL} st_t;
  st_t  st;
  logic force_q;
  logic beat;

  assign busy      = (st != IDLE);
  assign mem_valid = busy;
  assign beat      = mem_valid && mem_ready;
  assign mem_we    = (st == SV_VAL) || (st == SV_HDR);
  assign mem_addr  = (st == SV_HDR || st == RS_HDR) ? HDR_ADDR : VAL_ADDR;
  assign mem_wdata = (st == SV_VAL) ? rights
                   : (st == SV_HDR) ? (32'(inuse | force_q) << COMP_BIT) : 32'd0;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st      <= IDLE;
      rights  <= 32'd0;
      inuse   <= 1'b0;
      done    <= 1'b0;
      force_q <= 1'b0;
    end else begin
      done <= 1'b0;
      unique case (st)
        IDLE: begin
          if (save_req || restore_req) begin
            if (!feat_en) begin
              done <= 1'b1;
            end else if (save_req) begin
              st      <= SV_VAL;
              force_q <= force_inuse;
            end else begin
              st <= RS_HDR;
            end
          end else if (wr_en) begin
            rights <= wr_data;
            if (wr_data != 32'd0)       inuse <= 1'b1;
            else if (zero_clears_inuse) inuse <= 1'b0;
          end
        end
        SV_VAL: if (beat) st <= SV_HDR;
        SV_HDR: if (beat) begin
          st   <= IDLE;
          done <= 1'b1;
        end
        RS_HDR: if (beat) begin
          if (mem_rdata[COMP_BIT]) begin
            st <= RS_VAL;
          end else begin
            st     <= IDLE;
            rights <= 32'd0;
            inuse  <= 1'b0;
            done   <= 1'b1;
          end
        end
        RS_VAL: if (beat) begin
          st     <= IDLE;
          rights <= mem_rdata;
          inuse  <= (mem_rdata != 32'd0) || !zero_clears_inuse;
          done   <= 1'b1;
        end
        default: st <= IDLE;
      endcase
    end
  end

  assert_nonzero_sets_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && wr_en && !save_req && !restore_req && wr_data != 32'd0)
      |=> (inuse && rights == $past(wr_data)));

  assert_zero_keeps_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && wr_en && !save_req && !restore_req && wr_data == 32'd0 && !zero_clears_inuse)
      |=> (rights == 32'd0 && inuse == $past(inuse)));

  assert_zero_clears_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && wr_en && !save_req && !restore_req && wr_data == 32'd0 && zero_clears_inuse)
      |=> (rights == 32'd0 && !inuse));

  assert_hdr_bit_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_valid && mem_we && mem_addr == HDR_ADDR && inuse) |-> mem_wdata[COMP_BIT]);

  assert_clear_on_hdr0_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (beat && !mem_we && mem_addr == HDR_ADDR && !mem_rdata[COMP_BIT])
      |=> (rights == 32'd0 && !inuse && done));

  assert_load_value_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (beat && !mem_we && mem_addr == VAL_ADDR) |=> (rights == $past(mem_rdata)));

  assert_disabled_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !feat_en && (save_req || restore_req))
      |=> (!mem_valid && done && $stable(rights) && $stable(inuse)));

  assert_req_stable_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_valid && !mem_ready)
      |=> (mem_valid && $stable(mem_we) && $stable(mem_addr) && $stable(mem_wdata)));
endmodule

// File: tb/rights_xstate_unit_tb.sv
module rights_xstate_unit_tb;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 16;
  localparam logic [AW-1:0] HDR_A = 16'd512;
  localparam logic [AW-1:0] VAL_A = 16'd2688;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic feat_en = 1'b1, zero_clears_inuse = 1'b0;
  logic wr_en = 1'b0, save_req = 1'b0, restore_req = 1'b0, force_inuse = 1'b0;
  logic [31:0] wr_data = '0;
  logic [31:0] rights;
  logic inuse, busy, done, mem_valid, mem_ready, mem_we;
  logic [AW-1:0] mem_addr;
  logic [31:0] mem_wdata, mem_rdata;

  logic stall = 1'b0, tgl = 1'b0;
  logic [31:0] hdr_mem = '0, val_mem = '0;
  logic [31:0] hdr_init = '0, val_init = '0;
  logic load_mem = 1'b0;
  int beats = 0;
  logic [AW-1:0] alog [8];
  logic          wlog [8];
  int checks = 0, errors = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  assign mem_ready = stall ? tgl : 1'b1;
  assign mem_rdata = (mem_addr == HDR_A) ? hdr_mem : (mem_addr == VAL_A) ? val_mem : 32'hBAD0BAD0;

  always @(posedge clk) begin
    tgl <= ~tgl;
    if (load_mem) begin
      hdr_mem <= hdr_init;
      val_mem <= val_init;
    end else if (mem_valid && mem_ready) begin
      alog[beats % 8] <= mem_addr;
      wlog[beats % 8] <= mem_we;
      beats <= beats + 1;
      if (mem_we && mem_addr == HDR_A) hdr_mem <= mem_wdata;
      if (mem_we && mem_addr == VAL_A) val_mem <= mem_wdata;
    end
  end

  rights_xstate_unit #(.AW(AW), .BASE('0)) u_dut (
    .clk(clk), .rst_n(rst_n), .feat_en(feat_en), .zero_clears_inuse(zero_clears_inuse),
    .wr_en(wr_en), .wr_data(wr_data), .save_req(save_req), .restore_req(restore_req),
    .force_inuse(force_inuse), .rights(rights), .inuse(inuse), .busy(busy), .done(done),
    .mem_valid(mem_valid), .mem_ready(mem_ready), .mem_we(mem_we), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_rdata(mem_rdata));

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic set_mem(input logic [31:0] h, input logic [31:0] v);
    @(negedge clk); hdr_init = h; val_init = v; load_mem = 1'b1;
    @(negedge clk); load_mem = 1'b0;
  endtask

  task automatic write_reg(input logic [31:0] d);
    @(negedge clk); wr_en = 1'b1; wr_data = d;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic wait_done(input string req);
    int n = 0;
    while (!done && n < 50) begin @(negedge clk); n++; end
    check({req, " done seen"}, 32'(done), 32'd1);
    @(negedge clk);
    check({req, " done one cycle"}, 32'(done), 32'd0);
  endtask

  task automatic cmd(input logic sv, input logic rs, input logic frc, input string req);
    @(negedge clk); save_req = sv; restore_req = rs; force_inuse = frc;
    @(negedge clk); save_req = 1'b0; restore_req = 1'b0; force_inuse = 1'b0;
    wait_done(req);
  endtask

  task automatic t_reset;
    check("R1 rights", rights, 32'd0);
    check("R1 inuse", 32'(inuse), 32'd0);
    check("R1 mem_valid", 32'(mem_valid), 32'd0);
    check("R1 done", 32'(done), 32'd0);
  endtask

  task automatic t_writes;
    zero_clears_inuse = 1'b0;
    write_reg(32'hFFFF_FFF3);
    check("R2 rights", rights, 32'hFFFF_FFF3);
    check("R2 inuse", 32'(inuse), 32'd1);
    write_reg(32'd0);
    check("R3 rights", rights, 32'd0);
    check("R3 inuse kept", 32'(inuse), 32'd1);
    zero_clears_inuse = 1'b1;
    write_reg(32'd0);
    check("R4 inuse cleared", 32'(inuse), 32'd0);
  endtask

  task automatic t_save_basic;
    int b0;
    zero_clears_inuse = 1'b0;
    write_reg(32'h5555_5554);
    set_mem(32'hFFFF_FFFF, 32'h0);
    b0 = beats;
    cmd(1'b1, 1'b0, 1'b0, "R5 save");
    check("R5 beat count", 32'(beats - b0), 32'd2);
    check("R5 first addr", 32'(alog[b0 % 8]), 32'(VAL_A));
    check("R5 first is write", 32'(wlog[b0 % 8]), 32'd1);
    check("R5 second addr", 32'(alog[(b0 + 1) % 8]), 32'(HDR_A));
    check("R5 value stored", val_mem, 32'h5555_5554);
    check("R5 bitmap word", hdr_mem, 32'h0000_0200);
  endtask

  task automatic t_zero_roundtrip;
    int b0;
    zero_clears_inuse = 1'b1;
    write_reg(32'h0);
    cmd(1'b1, 1'b0, 1'b0, "R5 save zero");
    check("R5 bitmap bit clear", hdr_mem, 32'h0);
    set_mem(32'h0, 32'hDEAD_BEEF);
    write_reg(32'h1234_0000);
    b0 = beats;
    cmd(1'b0, 1'b1, 1'b0, "R6 restore");
    check("R6 one beat", 32'(beats - b0), 32'd1);
    check("R6 read bitmap", 32'(alog[b0 % 8]), 32'(HDR_A));
    check("R6 rights init", rights, 32'd0);
    check("R6 inuse clear", 32'(inuse), 32'd0);
  endtask

  task automatic t_force_roundtrip;
    int b0;
    zero_clears_inuse = 1'b1;
    write_reg(32'h0);
    cmd(1'b1, 1'b0, 1'b1, "R5 forced save");
    check("R5 forced bit", hdr_mem, 32'h0000_0200);
    set_mem(32'h0000_0200, 32'hFFFF_FFF0);
    b0 = beats;
    cmd(1'b0, 1'b1, 1'b0, "R7 restore");
    check("R7 two beats", 32'(beats - b0), 32'd2);
    check("R7 second addr", 32'(alog[(b0 + 1) % 8]), 32'(VAL_A));
    check("R7 loaded", rights, 32'hFFFF_FFF0);
    check("R7 inuse", 32'(inuse), 32'd1);
    set_mem(32'h0000_0200, 32'h0);
    cmd(1'b0, 1'b1, 1'b0, "R7 restore zero");
    check("R7 zero clears inuse", 32'(inuse), 32'd0);
    zero_clears_inuse = 1'b0;
    cmd(1'b0, 1'b1, 1'b0, "R7 restore zero keep");
    check("R7 zero keeps inuse set", 32'(inuse), 32'd1);
  endtask

  task automatic t_disabled;
    int b0;
    write_reg(32'hAAAA_0001);
    feat_en = 1'b0;
    b0 = beats;
    set_mem(32'h0, 32'h0);
    cmd(1'b1, 1'b0, 1'b0, "R8 save off");
    cmd(1'b0, 1'b1, 1'b0, "R8 restore off");
    check("R8 no beats", 32'(beats - b0), 32'd0);
    check("R8 rights kept", rights, 32'hAAAA_0001);
    check("R8 inuse kept", 32'(inuse), 32'd1);
    feat_en = 1'b1;
  endtask

  task automatic t_stall_busy;
    int b0;
    write_reg(32'h0BAD_F00D);
    stall = 1'b1;
    b0 = beats;
    @(negedge clk); save_req = 1'b1; restore_req = 1'b1;
    @(negedge clk); save_req = 1'b0; restore_req = 1'b0;
    wr_en = 1'b1; wr_data = 32'h1111_1111; restore_req = 1'b1;
    @(negedge clk); wr_en = 1'b0; restore_req = 1'b0;
    wait_done("R9 stalled save");
    stall = 1'b0;
    check("R11 save chosen first write", 32'(wlog[b0 % 8]), 32'd1);
    check("R9 beats under stall", 32'(beats - b0), 32'd2);
    check("R9 value stored", val_mem, 32'h0BAD_F00D);
    check("R10 write ignored", rights, 32'h0BAD_F00D);
    repeat (3) @(negedge clk);
    check("R10 restore ignored", 32'(beats - b0), 32'd2);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_writes();
    t_save_basic();
    t_zero_roundtrip();
    t_force_roundtrip();
    t_disabled();
    t_stall_busy();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule